// File: doc/BRIEF.md
# Pin Bank Controller with Edge Interrupts

A bank of general-purpose pins, up to 32 wide, controlled through a plain single-cycle register bus with 32-bit data. Each pin can be turned into an output or left as an input. Each pin can also have its logic sense inverted, and that inversion applies on the input path and on the driven path alike. Output bits are changed either by writing the whole data word or through three write-only strobe registers. These set, clear or invert only the bits written as 1, so software never has to read, modify and write the output word.

Inputs pass through a two-flop synchronizer. Edges are then detected on the value after inversion. Rising and falling detection each have their own enable bit per pin. A detected edge latches a bit in a write-one-to-clear interrupt status register, and records its direction in a companion edge register. The block raises a single interrupt line while any status bit is set. The byte offset of each of the ten registers is a separate parameter, so the bank can be placed into an existing address map.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset every register is zero, `pin_oe` is all zero, `irq` is 0 and `bus_rdata` is 0.
- R2: A 1 in the direction register (default offset 0x24) makes the matching pin an output, so its `pin_oe` bit is 1. A 0 leaves the pin as an input.
- R3: A write to the set register (0x2C) sets the output bits written as 1. A write to the clear register (0x30) zeroes them. A write to the invert register (0x34) flips them. Bits written as 0 keep their value. The result is visible one clock after the write.
- R4: `pin_out` bit n equals output bit n XOR polarity bit n, where the polarity register sits at default offset 0x28.
- R5: A read of the data register (0x20) returns the stored output bit for output pins, and the synchronized input XOR polarity for input pins. A write to the data register loads the output bits.
- R6: When the rising enable bit (0x08) of a pin is set, a 0-to-1 change of that pin's post-polarity input sets its status bit (0x00) three clocks after the pin changes.
- R7: When the falling enable bit (0x0C) of a pin is set, a 1-to-0 change sets the status bit. With both enable bits set, both directions are caught.
- R8: A pin whose rising and falling enable bits are both 0 latches no new status bit.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: The edge register (0x04) holds 1 for a pin whose latched event was rising and 0 for one that was falling. Writing 1 to a bit of this register clears that bit.
- R11: `irq` is 1 exactly when at least one status bit is set, and it changes in the same cycle as the status register.
- R12: When a clear write and a new edge reach the same status bit in the same cycle, the bit stays set and the edge register records the new edge.
- R13: With polarity set on an input pin, a physical falling transition is detected as a rising event.
- R14: Reads of the write-only strobe registers, and of offsets that match no register, return 0. Read data appears one clock after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (8) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data is returned on the following cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS (32) | Asynchronous pin inputs |
| pin_out | output | NPINS (32) | Driven pin values after polarity |
| pin_oe | output | NPINS (32) | Output enable per pin |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that the ten offset parameters are distinct, so at most one register is selected per access. They treat `pin_in` as free-running: the masking and interrupt properties hold for any input pattern, and the strobe properties depend only on the bus. The directed stimulus drives the bus and the pins only on falling clock edges, and issues one access at a time. It changes a pin's polarity only while that pin's edge enables are off, or when the inverted level cannot form an enabled edge, so every latched event is one the bench intended.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_DW = 32;
  localparam int NREG   = 10;

  // Logical register index; bit positions in the select vectors follow this.
  typedef enum logic [3:0] {
    RG_ISTAT = 4'd0,
    RG_EDGE  = 4'd1,
    RG_RENA  = 4'd2,
    RG_FENA  = 4'd3,
    RG_DATA  = 4'd4,
    RG_DIR   = 4'd5,
    RG_POL   = 4'd6,
    RG_SET   = 4'd7,
    RG_CLR   = 4'd8,
    RG_TOG   = 4'd9
  } reg_idx_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] OFF_ISTAT = 8'h00,
  parameter logic [AW-1:0] OFF_EDGE  = 8'h04,
  parameter logic [AW-1:0] OFF_RENA  = 8'h08,
  parameter logic [AW-1:0] OFF_FENA  = 8'h0C,
  parameter logic [AW-1:0] OFF_DATA  = 8'h20,
  parameter logic [AW-1:0] OFF_DIR   = 8'h24,
  parameter logic [AW-1:0] OFF_POL   = 8'h28,
  parameter logic [AW-1:0] OFF_SET   = 8'h2C,
  parameter logic [AW-1:0] OFF_CLR   = 8'h30,
  parameter logic [AW-1:0] OFF_TOG   = 8'h34
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit
);

  localparam logic [AW-1:0] OFFS [NREG] = '{
    OFF_ISTAT, OFF_EDGE, OFF_RENA, OFF_FENA, OFF_DATA,
    OFF_DIR, OFF_POL, OFF_SET, OFF_CLR, OFF_TOG
  };

  for (genvar r = 0; r < NREG; r++) begin : g_cmp
    assign hit[r] = (addr == OFFS[r]);
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] d_async,
  output logic [NPINS-1:0] d_sync
);

  logic [NPINS-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] level,     // synchronized, post-polarity
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  input  logic [NPINS-1:0] stat_clr,  // write-one-to-clear mask, status
  input  logic [NPINS-1:0] edge_clr,  // write-one-to-clear mask, edge kind
  output logic [NPINS-1:0] stat_q,
  output logic [NPINS-1:0] edge_q,
  output logic             irq_q
);

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] stat_d;

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic up_ev, dn_ev, ev;
    assign up_ev = level[n] & ~prev_q[n] & rise_en[n];
    assign dn_ev = ~level[n] & prev_q[n] & fall_en[n];
    assign ev    = up_ev | dn_ev;
    // a fresh event beats a clear in the same cycle
    assign stat_d[n] = ev | (stat_q[n] & ~stat_clr[n]);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[n] <= 1'b0;
        stat_q[n] <= 1'b0;
        edge_q[n] <= 1'b0;
      end else begin
        prev_q[n] <= level[n];
        stat_q[n] <= stat_d[n];
        if (ev)               edge_q[n] <= up_ev;
        else if (edge_clr[n]) edge_q[n] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |stat_d;
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  parameter logic [AW-1:0] OFF_ISTAT = 8'h00,
  parameter logic [AW-1:0] OFF_EDGE  = 8'h04,
  parameter logic [AW-1:0] OFF_RENA  = 8'h08,
  parameter logic [AW-1:0] OFF_FENA  = 8'h0C,
  parameter logic [AW-1:0] OFF_DATA  = 8'h20,
  parameter logic [AW-1:0] OFF_DIR   = 8'h24,
  parameter logic [AW-1:0] OFF_POL   = 8'h28,
  parameter logic [AW-1:0] OFF_SET   = 8'h2C,
  parameter logic [AW-1:0] OFF_CLR   = 8'h30,
  parameter logic [AW-1:0] OFF_TOG   = 8'h34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  logic [NREG-1:0]   hit;
  logic [NREG-1:0]   wr_hit;
  logic [NPINS-1:0]  wmask;
  logic [NPINS-1:0]  in_sync;
  logic [NPINS-1:0]  in_level;
  logic [NPINS-1:0]  out_q, dir_q, pol_q, ren_q, fen_q;
  logic [NPINS-1:0]  stat_q, edge_q;
  logic [NPINS-1:0]  data_view;
  logic [BUS_DW-1:0] rd_val;
  logic [BUS_DW-1:0] rdata_q;

  function automatic logic [BUS_DW-1:0] zx(input logic [NPINS-1:0] v);
    logic [BUS_DW-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  gpio_addr_dec #(
    .AW(AW),
    .OFF_ISTAT(OFF_ISTAT), .OFF_EDGE(OFF_EDGE), .OFF_RENA(OFF_RENA),
    .OFF_FENA(OFF_FENA), .OFF_DATA(OFF_DATA), .OFF_DIR(OFF_DIR),
    .OFF_POL(OFF_POL), .OFF_SET(OFF_SET), .OFF_CLR(OFF_CLR),
    .OFF_TOG(OFF_TOG)
  ) u_dec (
    .addr(bus_addr),
    .hit (hit)
  );

  assign wr_hit = bus_wr ? hit : '0;
  assign wmask  = bus_wdata[NPINS-1:0];

  gpio_in_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(pin_in),
    .d_sync (in_sync)
  );

  assign in_level = in_sync ^ pol_q;

  gpio_edge_unit #(.NPINS(NPINS)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .level   (in_level),
    .rise_en (ren_q),
    .fall_en (fen_q),
    .stat_clr(wr_hit[RG_ISTAT] ? wmask : '0),
    .edge_clr(wr_hit[RG_EDGE]  ? wmask : '0),
    .stat_q  (stat_q),
    .edge_q  (edge_q),
    .irq_q   (irq)
  );

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      pol_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
    end else begin
      if (wr_hit[RG_DIR])  dir_q <= wmask;
      if (wr_hit[RG_POL])  pol_q <= wmask;
      if (wr_hit[RG_RENA]) ren_q <= wmask;
      if (wr_hit[RG_FENA]) fen_q <= wmask;
    end
  end

  // Output bits: whole-word load or masked strobes (one access per cycle)
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else begin
      if (wr_hit[RG_DATA])     out_q <= wmask;
      else if (wr_hit[RG_SET]) out_q <= out_q | wmask;
      else if (wr_hit[RG_CLR]) out_q <= out_q & ~wmask;
      else if (wr_hit[RG_TOG]) out_q <= out_q ^ wmask;
    end
  end

  assign pin_out   = out_q ^ pol_q;
  assign pin_oe    = dir_q;
  assign data_view = (dir_q & out_q) | (~dir_q & in_level);

  always_comb begin
    rd_val = '0;
    unique case (1'b1)
      hit[RG_ISTAT]: rd_val = zx(stat_q);
      hit[RG_EDGE]:  rd_val = zx(edge_q);
      hit[RG_RENA]:  rd_val = zx(ren_q);
      hit[RG_FENA]:  rd_val = zx(fen_q);
      hit[RG_DATA]:  rd_val = zx(data_view);
      hit[RG_DIR]:   rd_val = zx(dir_q);
      hit[RG_POL]:   rd_val = zx(pol_q);
      default:       rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [NREG-1:0]  wr_hit,
  input logic [NPINS-1:0] wmask,
  input logic [NPINS-1:0] out_q,
  input logic [NPINS-1:0] ren_q,
  input logic [NPINS-1:0] fen_q,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq
);

  assert_reset_clean_R1: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && pin_oe == '0 && irq == 1'b0));

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hit[RG_SET] |=> ((out_q & $past(wmask)) == $past(wmask)));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hit[RG_CLR] |=> ((out_q & $past(wmask)) == '0));

  assert_tog_bits_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hit[RG_TOG] |=> (out_q == ($past(out_q) ^ $past(wmask))));

  assert_masked_pin_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~($past(ren_q) | $past(fen_q))) == '0));

  assert_irq_or_R11: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_q != '0));

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr_hit(wr_hit),
  .wmask (wmask),
  .out_q (out_q),
  .ren_q (ren_q),
  .fen_q (fen_q),
  .stat_q(stat_q),
  .pin_oe(pin_oe),
  .irq   (irq)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;

  localparam int NP = 32;

  localparam logic [7:0] A_ISTAT = 8'h00, A_EDGE = 8'h04, A_RENA = 8'h08,
                         A_FENA = 8'h0C, A_DATA = 8'h20, A_DIR = 8'h24,
                         A_POL = 8'h28, A_SET = 8'h2C, A_CLR = 8'h30,
                         A_TOG = 8'h34;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          irq;

  int nvec = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pin_oe", {31'b0, 1'b0} | pin_oe, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd(A_ISTAT, v); chk("R1 status", v, 32'h0);
    rd(A_DIR, v);   chk("R1 dir", v, 32'h0);
  endtask

  task automatic t_outputs();
    logic [31:0] v;
    wr(A_DIR, 32'hFFFF_FFFF);
    chk("R2 pin_oe all out", pin_oe, 32'hFFFF_FFFF);
    wr(A_SET, 32'h0000_00F0);
    chk("R3 set", pin_out, 32'h0000_00F0);
    wr(A_CLR, 32'h0000_0030);
    chk("R3 clear", pin_out, 32'h0000_00C0);
    wr(A_TOG, 32'h0000_0081);
    chk("R3 toggle", pin_out, 32'h0000_0041);
    rd(A_DATA, v); chk("R5 data out", v, 32'h0000_0041);
    wr(A_POL, 32'h0000_000F);
    chk("R4 polarity drive", pin_out, 32'h0000_004E);
    rd(A_DATA, v); chk("R5 data out logical", v, 32'h0000_0041);
    wr(A_POL, 32'h0);
    wr(A_DIR, 32'h0000_FFFF);
    chk("R2 pin_oe half", pin_oe, 32'h0000_FFFF);
    wr(A_DIR, 32'h0);
  endtask

  task automatic t_inputs();
    logic [31:0] v;
    pin_in = 32'hA5A5_0000;
    wr(A_POL, 32'h0000_FFFF);
    settle();
    rd(A_DATA, v); chk("R5 data in", v, 32'hA5A5_FFFF);
    wr(A_POL, 32'h0);
    pin_in = '0;
    wr(A_DATA, 32'h0000_1234);
    chk("R5 data write", pin_out, 32'h0000_1234);
    settle();
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(A_RENA, 32'h1);
    @(negedge clk); pin_in[0] = 1'b1;
    settle();
    rd(A_ISTAT, v); chk("R6 rise status", v, 32'h1);
    rd(A_EDGE, v);  chk("R10 rise kind", v, 32'h1);
    chk("R11 irq high", {31'b0, irq}, 32'h1);
    wr(A_ISTAT, 32'h1);
    chk("R11 irq low", {31'b0, irq}, 32'h0);
    rd(A_ISTAT, v); chk("R9 cleared", v, 32'h0);
    rd(A_EDGE, v);  chk("R10 kind kept", v, 32'h1);
    wr(A_EDGE, 32'h1);
    rd(A_EDGE, v);  chk("R10 kind cleared", v, 32'h0);
  endtask

  task automatic t_fall_both();
    logic [31:0] v;
    @(negedge clk); pin_in[1] = 1'b1;
    settle();
    wr(A_FENA, 32'h0000_0006);
    wr(A_RENA, 32'h0000_0005);
    rd(A_ISTAT, v); chk("R7 no event yet", v, 32'h0);
    @(negedge clk); pin_in[1] = 1'b0;
    settle();
    rd(A_ISTAT, v); chk("R7 fall status", v, 32'h2);
    rd(A_EDGE, v);  chk("R10 fall kind", v, 32'h0);
    @(negedge clk); pin_in[2] = 1'b1;
    settle();
    rd(A_ISTAT, v); chk("R7 both rise", v, 32'h6);
    rd(A_EDGE, v);  chk("R10 both rise kind", v, 32'h4);
    wr(A_ISTAT, 32'h0);
    rd(A_ISTAT, v); chk("R9 zero write", v, 32'h6);
    wr(A_ISTAT, 32'h4);
    rd(A_ISTAT, v); chk("R9 partial clear", v, 32'h2);
    @(negedge clk); pin_in[2] = 1'b0;
    settle();
    rd(A_ISTAT, v); chk("R7 both fall", v, 32'h6);
    rd(A_EDGE, v);  chk("R10 both fall kind", v, 32'h0);
    wr(A_ISTAT, 32'hFFFF_FFFF);
    wr(A_EDGE, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(A_RENA, 32'h0);
    wr(A_FENA, 32'h0);
    @(negedge clk); pin_in[3] = 1'b1; pin_in[0] = 1'b0;
    settle();
    @(negedge clk); pin_in[3] = 1'b0;
    settle();
    rd(A_ISTAT, v); chk("R8 masked status", v, 32'h0);
    chk("R8 masked irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_inv_edge();
    logic [31:0] v;
    @(negedge clk); pin_in[4] = 1'b1;
    settle();
    wr(A_POL, 32'h10);
    wr(A_RENA, 32'h10);
    settle();
    rd(A_ISTAT, v); chk("R13 quiet", v, 32'h0);
    @(negedge clk); pin_in[4] = 1'b0;
    settle();
    rd(A_ISTAT, v); chk("R13 inverted rise", v, 32'h10);
    rd(A_EDGE, v);  chk("R13 kind rising", v, 32'h10);
    wr(A_ISTAT, 32'h10);
    wr(A_EDGE, 32'h10);
    wr(A_RENA, 32'h0);
    wr(A_POL, 32'h0);
    settle();
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(A_RENA, 32'h20);
    wr(A_FENA, 32'h20);
    @(negedge clk); pin_in[5] = 1'b1;
    settle();
    rd(A_ISTAT, v); chk("R12 first event", v, 32'h20);
    @(negedge clk); pin_in[5] = 1'b0;
    @(negedge clk);
    wr(A_ISTAT, 32'h20);     // clear lands with the falling event
    rd(A_ISTAT, v); chk("R12 edge wins", v, 32'h20);
    rd(A_EDGE, v);  chk("R12 new kind", v, 32'h0);
    wr(A_ISTAT, 32'h20);
    rd(A_ISTAT, v); chk("R12 later clear", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(A_SET, v);   chk("R14 set reads 0", v, 32'h0);
    rd(A_TOG, v);   chk("R14 tog reads 0", v, 32'h0);
    rd(8'h10, v);   chk("R14 hole reads 0", v, 32'h0);
    rd(A_FENA, v);  chk("R14 fena readback", v, 32'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_outputs();
    t_inputs();
    t_rise();
    t_fall_both();
    t_mask();
    t_inv_edge();
    t_race();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule